// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Dispatcher

This block sends software interrupts between processors. A processor issues a 32-bit command word. The word names one of the software interrupt lines and says which processors receive it. For every pair of target processor and interrupt line, the block keeps a bitmap of the processors that asked for that interrupt. A target counts as pending while its bitmap is non-empty.

When a target acknowledges a line, the block gives back the line number together with one requester: the lowest-numbered processor in the bitmap. That requester's bit is then cleared. As a result, several requests that arrive before the target services them are each reported once, instead of being merged into one. Two side ports set or clear bitmap bits directly, and a read port exposes any bitmap. Priority arbitration between lines is done outside the block, which receives the chosen line on the acknowledge port.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every bitmap reads zero, every `pend` bit is low, and `pend` bit `t*NSGI+i` stands for target `t`, line `i`.
- R2: The command word is laid out as follows: bits [9:0] hold the line ID, bits [23:16] hold the target list, and bits [25:24] hold the filter. With filter 0, the targets are the listed processors, and list bits at or above NCPU are ignored.
- R3: Filter 1 targets every processor except the writer `cmd_cpu`.
- R4: Filter 2 targets only the writer.
- R5: Filter 3 is treated as all processors, the writer included.
- R6: For each target, a command sets the writer's bit in that target's bitmap for the line, which makes the target pending. A command whose ID is NSGI or higher changes nothing.
- R7: An acknowledge to a non-empty bitmap returns `ack_data` with the line ID in bits [9:0] and the lowest set source number in bits [12:10], and that bit is cleared on the next edge. The target stays pending while other source bits remain.
- R8: An acknowledge to an empty bitmap raises `ack_err` and returns 1023 in bits [9:0]. `ack_err` never rises without `ack_valid`.
- R9: A source-clear write removes the given bits from one bitmap. Pending drops once the bitmap is empty.
- R10: A source-set write ORs the given bits into one bitmap, which makes that target pending when the bits are non-zero.
- R11: When several updates hit the same bitmap in one cycle, they are applied in this order: the acknowledge clear first, then the source clear, then the source set, then the command. A request arriving together with an acknowledge is therefore kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_cpu | input | CW | Processor writing the command |
| cmd_word | input | 32 | Command word |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CW | Acknowledging target processor |
| ack_id | input | IW | Line being acknowledged |
| ack_data | output | 13 | Source number and line ID, or 1023 |
| ack_err | output | 1 | Acknowledge hit an empty bitmap |
| sclr_valid | input | 1 | Source-clear strobe |
| sset_valid | input | 1 | Source-set strobe |
| s_cpu | input | CW | Target for set/clear |
| s_id | input | IW | Line for set/clear |
| s_bits | input | NCPU | Source bits to set or clear |
| rd_cpu | input | CW | Target for bitmap read |
| rd_id | input | IW | Line for bitmap read |
| rd_src | output | NCPU | Selected bitmap |
| pend | output | NCPU*NSGI | Pending flags, index target*NSGI+line |

## Verification
The bench builds the block with its default values of eight processors and sixteen lines, so the full 3-bit source field is exercised. It also covers a target list that reaches the top processor, and a writer that must be excluded from, or alone in, the target set. With three requesters queued on one entry, the bench checks that acknowledges return them in ascending order, followed by a spurious return once the bitmap is empty. It also drives an acknowledge and a new request to the same entry in the same cycle.

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NCPU = 8,
  parameter int NSGI = 16,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IW = (NSGI > 1) ? $clog2(NSGI) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [CW-1:0]        cmd_cpu,
  input  logic [31:0]          cmd_word,
  input  logic                 ack_valid,
  input  logic [CW-1:0]        ack_cpu,
  input  logic [IW-1:0]        ack_id,
  output logic [12:0]          ack_data,
  output logic                 ack_err,
  input  logic                 sclr_valid,
  input  logic                 sset_valid,
  input  logic [CW-1:0]        s_cpu,
  input  logic [IW-1:0]        s_id,
  input  logic [NCPU-1:0]      s_bits,
  input  logic [CW-1:0]        rd_cpu,
  input  logic [IW-1:0]        rd_id,
  output logic [NCPU-1:0]      rd_src,
  output logic [NCPU*NSGI-1:0] pend
);

  logic [NCPU-1:0] srcq [NCPU][NSGI];
  logic [NCPU-1:0] wr_oh, tgt, cur;
  logic [CW-1:0]   lo;
  logic            cmd_ok;
  logic            unused_bits;

  assign unused_bits = ^{cmd_word[31:26], cmd_word[15:10]};
  assign wr_oh  = NCPU'(1) << cmd_cpu;
  assign cmd_ok = cmd_valid && (cmd_word[9:IW] == '0);

  always_comb begin
    case (cmd_word[25:24])
      2'd0:    tgt = cmd_word[16 +: NCPU];
      2'd1:    tgt = ~wr_oh;
      2'd2:    tgt = wr_oh;
      default: tgt = '1;
    endcase
  end

  function automatic logic [NCPU-1:0] upd(
    input logic [NCPU-1:0] v, input logic a, c, s, m,
    input logic [NCPU-1:0] b, w);
    logic [NCPU-1:0] r;
    r = a ? (v & (v - 1'b1)) : v;
    if (c) r = r & ~b;
    if (s) r = r | b;
    if (m) r = r | w;
    return r;
  endfunction

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar i = 0; i < NSGI; i++) begin : g_sgi
      logic hit_a, hit_c, hit_s, hit_m;
      assign hit_a = ack_valid  && ack_cpu == CW'(t) && ack_id == IW'(i);
      assign hit_c = sclr_valid && s_cpu == CW'(t) && s_id == IW'(i);
      assign hit_s = sset_valid && s_cpu == CW'(t) && s_id == IW'(i);
      assign hit_m = cmd_ok && tgt[t] && cmd_word[IW-1:0] == IW'(i);
      always_ff @(posedge clk) begin
        if (!rst_n) srcq[t][i] <= '0;
        else        srcq[t][i] <= upd(srcq[t][i], hit_a, hit_c, hit_s, hit_m, s_bits, wr_oh);
      end
      assign pend[t*NSGI+i] = |srcq[t][i];
    end
  end

  assign cur = srcq[ack_cpu][ack_id];

  always_comb begin
    lo = '0;
    for (int k = NCPU-1; k >= 0; k--)
      if (cur[k]) lo = CW'(k);
  end

  assign ack_err  = ack_valid && (cur == '0);
  assign ack_data = (cur == '0) ? {3'd0, 10'd1023} : {3'(lo), 10'(ack_id)};
  assign rd_src   = srcq[rd_cpu][rd_id];

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCPU = 8,
  parameter int NSGI = 16,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IW = (NSGI > 1) ? $clog2(NSGI) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [CW-1:0]        cmd_cpu,
  input logic [9:0]           cmd_id,
  input logic [1:0]           cmd_flt,
  input logic                 ack_valid,
  input logic [CW-1:0]        ack_cpu,
  input logic [IW-1:0]        ack_id,
  input logic [12:0]          ack_data,
  input logic                 ack_err,
  input logic [CW-1:0]        rd_cpu,
  input logic [IW-1:0]        rd_id,
  input logic [NCPU-1:0]      rd_src,
  input logic [NCPU*NSGI-1:0] pend
);

  assert_spurious_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> ack_data[9:0] == 10'd1023);

  assert_err_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> !ack_err);

  assert_ack_returns_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_err) |-> ack_data[9:0] == 10'(ack_id));

  assert_lowest_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_err && rd_cpu == ack_cpu && rd_id == ack_id) |->
      (rd_src[ack_data[12:10]] &&
       ((rd_src & ((NCPU'(1) << ack_data[12:10]) - 1'b1)) == '0)));

  assert_self_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_flt == 2'd2 && cmd_id < 10'(NSGI)) |=>
      pend[$past(cmd_cpu)*NSGI + int'($past(cmd_id))]);

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NSGI(NSGI)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cpu(cmd_cpu),
  .cmd_id(cmd_word[9:0]), .cmd_flt(cmd_word[25:24]),
  .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
  .ack_data(ack_data), .ack_err(ack_err), .rd_cpu(rd_cpu), .rd_id(rd_id),
  .rd_src(rd_src), .pend(pend));

// File: tb/sgi_dispatch_tb_top.sv
module sgi_dispatch_tb_top;
  localparam int NCPU = 8, NSGI = 16, CW = 3, IW = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, ack_valid = 0, sclr_valid = 0, sset_valid = 0;
  logic [CW-1:0] cmd_cpu = 0, ack_cpu = 0, s_cpu = 0, rd_cpu = 0;
  logic [IW-1:0] ack_id = 0, s_id = 0, rd_id = 0;
  logic [31:0] cmd_word = 0;
  logic [NCPU-1:0] s_bits = 0, rd_src;
  logic [12:0] ack_data;
  logic ack_err;
  logic [NCPU*NSGI-1:0] pend;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sgi_dispatch #(.NCPU(NCPU), .NSGI(NSGI)) dut_i (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NCPU*NSGI-1:0] pmask(logic [NCPU-1:0] t, int id);
    logic [NCPU*NSGI-1:0] m = '0;
    for (int k = 0; k < NCPU; k++) if (t[k]) m[k*NSGI+id] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] mk(int id, int flt, logic [7:0] lst);
    return {6'd0, 2'(flt), lst, 6'd0, 10'(id)};
  endfunction

  task automatic do_cmd(int cpu, logic [31:0] w);
    @(negedge clk); cmd_valid = 1; cmd_cpu = CW'(cpu); cmd_word = w;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic do_ack(int cpu, int id, output logic [12:0] d, output logic e);
    @(negedge clk); ack_valid = 1; ack_cpu = CW'(cpu); ack_id = IW'(id);
    #1 d = ack_data; e = ack_err;
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic do_src(bit set, int cpu, int id, logic [NCPU-1:0] b);
    @(negedge clk); sset_valid = set; sclr_valid = !set;
    s_cpu = CW'(cpu); s_id = IW'(id); s_bits = b;
    @(negedge clk); sset_valid = 0; sclr_valid = 0;
  endtask

  task automatic rd(int cpu, int id, output logic [NCPU-1:0] v);
    rd_cpu = CW'(cpu); rd_id = IW'(id); #1 v = rd_src;
  endtask

  task automatic wipe();
    for (int t = 0; t < NCPU; t++)
      for (int i = 0; i < NSGI; i++) do_src(0, t, i, '1);
  endtask

  task automatic t_reset();
    logic [12:0] d; logic e; logic [NCPU-1:0] v;
    check("R1 pend", pend, '0);
    rd(7, 15, v); check("R1 bitmap", v, '0);
    do_ack(3, 2, d, e);
    check("R8 err", e, 1); check("R8 data", d[9:0], 1023);
  endtask

  task automatic t_filters();
    logic [NCPU-1:0] v;
    do_cmd(2, mk(5, 0, 8'b1010_0001));
    check("R2 list", pend, pmask(8'b1010_0001, 5));
    rd(5, 5, v); check("R6 src bit", v, 8'h04);
    wipe();
    do_cmd(3, mk(0, 1, 8'h00));
    check("R3 others", pend, pmask(8'hF7, 0));
    rd(0, 0, v); check("R3 src bit", v, 8'h08);
    wipe();
    do_cmd(6, mk(15, 2, 8'hFF));
    check("R4 self", pend, pmask(8'h40, 15));
    wipe();
    do_cmd(1, mk(9, 3, 8'h00));
    check("R5 all", pend, pmask(8'hFF, 9));
    wipe();
    do_cmd(1, mk(16, 3, 8'h00));
    check("R6 bad id", pend, '0);
  endtask

  task automatic t_ack();
    logic [12:0] d; logic e; logic [NCPU-1:0] v;
    do_cmd(4, mk(7, 0, 8'h04));
    do_cmd(1, mk(7, 0, 8'h04));
    do_cmd(6, mk(7, 0, 8'h04));
    rd(2, 7, v); check("R6 sources", v, 8'h52);
    do_ack(2, 7, d, e); check("R7 first", {e, d}, {1'b0, 3'd1, 10'd7});
    check("R7 still pend", pend[2*NSGI+7], 1);
    do_ack(2, 7, d, e); check("R7 second", {e, d}, {1'b0, 3'd4, 10'd7});
    do_ack(2, 7, d, e); check("R7 third", {e, d}, {1'b0, 3'd6, 10'd7});
    check("R7 drained", pend, '0);
    do_ack(2, 7, d, e); check("R8 empty", {e, d[9:0]}, {1'b1, 10'd1023});
  endtask

  task automatic t_setclr();
    logic [NCPU-1:0] v;
    do_src(1, 3, 11, 8'h30);
    rd(3, 11, v); check("R10 set", v, 8'h30);
    check("R10 pend", pend, pmask(8'h08, 11));
    do_src(0, 3, 11, 8'h10);
    rd(3, 11, v); check("R9 partial", v, 8'h20);
    check("R9 pend kept", pend[3*NSGI+11], 1);
    do_src(0, 3, 11, 8'h20);
    check("R9 pend drop", pend, '0);
  endtask

  task automatic t_same();
    logic [12:0] d; logic e; logic [NCPU-1:0] v;
    do_cmd(2, mk(4, 0, 8'h01));
    @(negedge clk);
    ack_valid = 1; ack_cpu = 0; ack_id = 4;
    cmd_valid = 1; cmd_cpu = 2; cmd_word = mk(4, 0, 8'h01);
    #1 d = ack_data; e = ack_err;
    @(negedge clk); ack_valid = 0; cmd_valid = 0;
    check("R11 ack data", {e, d}, {1'b0, 3'd2, 10'd4});
    rd(0, 4, v); check("R11 kept", v, 8'h04);
    check("R11 pend", pend[4], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_filters();
    wipe();
    t_ack();
    t_setclr();
    t_same();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule